// File: doc/BRIEF.md
# Bus-Master IDE DMA Register File

This block holds the software-visible control state for a two-channel bus-master IDE DMA engine. A host reaches it through a small I/O window of 16 bytes. Each channel owns 8 bytes of that window: a command/status group in its lower half and a 32-bit descriptor-table pointer in its upper half. The host issues single-cycle reads and writes with a size code. The block decodes them, updates the channel registers and returns read data combinationally in the same cycle.

On the engine side, each channel drives a start/stop line and a transfer-direction line taken from its command byte. It also takes three inputs from the engine: a level that reports an active transfer, and one-cycle pulses for an error and for an interrupt. The status byte mixes three kinds of bits. One bit mirrors the hardware level. Two bits latch events and are cleared by writing a one. Two bits are plain host storage. The remaining bits are always zero.

Size codes on `io_size` are: 0 = byte, 1 = halfword, 2 = word, 3 = reserved. Write data and read data are always aligned to bit 0 of the data bus.

Top module: `bmide_regfile`

## Requirements
- R1: A synchronous active-high reset clears every command byte, status byte and descriptor pointer to zero, so `start_o` and `dir_o` read 0 after reset.
- R2: Address bit 3 selects the channel. Within a channel, offset 0 is the command byte, offset 2 is the status byte and offsets 4–7 hold the pointer. An access to one channel never changes the other.
- R3: A byte read at channel offset 1 or 3 returns 0xFF.
- R4: A read of the command/status group with any size other than byte returns all ones for that width: 0x0000FFFF for a halfword, and 0xFFFFFFFF for a word or for the reserved code.
- R5: A write to the command/status group with any size other than byte changes nothing.
- R6: Only command bits 0 (start/stop) and 3 (direction) are stored. Other command bits read as 0. `start_o` equals command bit 0 and `dir_o` equals command bit 3 of the same channel.
- R7: A status write loads bits 5 and 6 from the written data. Bit 0 ignores the written data.
- R8: A status write clears bit 1 and bit 2 where the written data holds a 1, and keeps them where it holds a 0.
- R9: Status bits 3, 4 and 7 always read as 0.
- R10: Status bit 0 holds the channel's `dma_active_i` level sampled at the previous clock edge.
- R11: An `err_evt_i` pulse sets status bit 1 and an `irq_evt_i` pulse sets status bit 2. When a pulse arrives in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R12: A pointer access at channel offset 4+k (k = 0..3) with a size of byte, halfword or word touches pointer bytes k upward. A byte access touches 1 byte, a halfword 2 and a word 4, and lanes past byte 3 are dropped. Write data byte 0 lands in pointer byte k. A read returns the pointer shifted right by 8k bits and masked to the access width. Pointer bits 1:0 always read 0. A reserved-size write to the pointer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Byte address inside the I/O window |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wr | input | 1 | Write strobe, one cycle |
| io_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| io_wdata | input | 32 | Write data, aligned to bit 0 |
| io_rdata | output | 32 | Read data, valid in the cycle of `io_rd`, zero otherwise |
| dma_active_i | input | 2 | Per-channel transfer-active level from the engine |
| err_evt_i | input | 2 | Per-channel one-cycle error pulse |
| irq_evt_i | input | 2 | Per-channel one-cycle interrupt pulse |
| start_o | output | 2 | Per-channel start/stop control |
| dir_o | output | 2 | Per-channel transfer direction |

## Verification
Some rules hold on every cycle, and the embedded properties check those:
- the reserved status and command bits stay zero;
- the pointer stays aligned;
- the active bit tracks the engine level with one cycle of lag;
- an event pulse always leaves its bit set;
- a write-one-to-clear without a competing pulse really clears;
- non-byte writes leave the command/status group untouched;
- at most one channel is selected.

Only the bench scenarios can show the rest:
- the values returned by the read mux at each offset and size;
- the byte-lane placement of partial pointer writes;
- the read-back of the capability bits;
- the separation of the two channels.

// File: rtl/bmide_pkg.sv
package bmide_pkg;

    localparam int IO_DW    = 32;
    localparam int PTR_W    = 32;
    localparam int GRP_BYTES = 4;

    localparam logic [1:0] CMD_OFS  = 2'd0;
    localparam logic [1:0] STAT_OFS = 2'd2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } io_size_e;

    // Command byte: bit 3 direction, bit 0 start/stop
    typedef struct packed {
        logic [3:0] rsvd_hi;
        logic       dir;
        logic [1:0] rsvd_mid;
        logic       start;
    } cmd_t;

    // Status byte: 6:5 host capability, 2 interrupt, 1 error, 0 active
    typedef struct packed {
        logic       rsvd7;
        logic       cap_hi;
        logic       cap_lo;
        logic [1:0] rsvd43;
        logic       irq;
        logic       err;
        logic       active;
    } stat_t;

    function automatic logic [IO_DW-1:0] size_ones(io_size_e s);
        case (s)
            SZ_BYTE: size_ones = 32'h0000_00FF;
            SZ_HALF: size_ones = 32'h0000_FFFF;
            default: size_ones = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [GRP_BYTES-1:0] lane_en(logic [1:0] ofs, io_size_e s);
        logic [7:0] base;
        logic [7:0] shifted;
        case (s)
            SZ_BYTE: base = 8'h01;
            SZ_HALF: base = 8'h03;
            SZ_WORD: base = 8'h0F;
            default: base = 8'h00;
        endcase
        shifted = base << ofs;
        lane_en = shifted[GRP_BYTES-1:0];
    endfunction

    function automatic stat_t status_next(stat_t cur, logic [7:0] wd, logic wr_en,
                                          logic active, logic err_p, logic irq_p);
        stat_t n;
        n        = '0;
        n.active = active;
        n.err    = (cur.err & ~(wr_en & wd[1])) | err_p;
        n.irq    = (cur.irq & ~(wr_en & wd[2])) | irq_p;
        n.cap_lo = wr_en ? wd[5] : cur.cap_lo;
        n.cap_hi = wr_en ? wd[6] : cur.cap_hi;
        status_next = n;
    endfunction

endpackage

// File: rtl/bmide_decode.sv
module bmide_decode
    import bmide_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 3 + $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic [NCH-1:0]    ch_sel,
    output logic [ADDR_W-4:0] ch_idx,
    output logic              grp_ptr,
    output logic [1:0]        ofs
);

    assign ch_idx  = addr[ADDR_W-1:3];
    assign grp_ptr = addr[2];
    assign ofs     = addr[1:0];

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        assign ch_sel[c] = (rd | wr) && (ch_idx == c[ADDR_W-4:0]);
    end

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_sel));

endmodule

// File: rtl/bmide_chan.sv
module bmide_chan
    import bmide_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             wr,
    input  logic             grp_ptr,
    input  logic [1:0]       ofs,
    input  io_size_e         size,
    input  logic [IO_DW-1:0] wdata,
    input  logic             dma_active,
    input  logic             err_evt,
    input  logic             irq_evt,
    output logic [IO_DW-1:0] rdata,
    output logic             start,
    output logic             dir
);

    cmd_t             cmd_q;
    stat_t            stat_q, stat_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;

    logic wr_here, byte_acc, cmd_wr, st_wr, ptr_wr;
    logic [GRP_BYTES-1:0] lanes;
    logic [PTR_W-1:0]     lane_mask, wshift;

    assign wr_here  = sel & wr;
    assign byte_acc = (size == SZ_BYTE);
    assign cmd_wr   = wr_here & ~grp_ptr & byte_acc & (ofs == CMD_OFS);
    assign st_wr    = wr_here & ~grp_ptr & byte_acc & (ofs == STAT_OFS);
    assign ptr_wr   = wr_here & grp_ptr;
    assign lanes    = lane_en(ofs, size);

    for (genvar b = 0; b < GRP_BYTES; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{lanes[b]}};
    end

    always_comb begin
        wshift = wdata << {ofs, 3'b000};
        ptr_d  = (ptr_q & ~lane_mask) | (wshift & lane_mask);
        ptr_d[1:0] = 2'b00;
        stat_d = status_next(stat_q, wdata[7:0], st_wr, dma_active, err_evt, irq_evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            stat_q <= '0;
            ptr_q  <= '0;
        end else begin
            stat_q <= stat_d;
            if (cmd_wr) begin
                cmd_q       <= '0;
                cmd_q.start <= wdata[0];
                cmd_q.dir   <= wdata[3];
            end
            if (ptr_wr) begin
                ptr_q <= ptr_d;
            end
        end
    end

    always_comb begin
        if (grp_ptr) begin
            rdata = (ptr_q >> {ofs, 3'b000}) & size_ones(size);
        end else if (!byte_acc) begin
            rdata = size_ones(size);
        end else begin
            case (ofs)
                CMD_OFS:  rdata = {24'h0, cmd_q};
                STAT_OFS: rdata = {24'h0, stat_q};
                default:  rdata = 32'h0000_00FF;
            endcase
        end
    end

    assign start = cmd_q.start;
    assign dir   = cmd_q.dir;

    assert_stat_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_q.rsvd7 == 1'b0) && (stat_q.rsvd43 == 2'b00));

    assert_cmd_rsvd_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.rsvd_hi == 4'h0) && (cmd_q.rsvd_mid == 2'b00));

    assert_active_follow_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stat_q.active == $past(dma_active)));

    assert_evt_sets_R11: assert property (@(posedge clk) disable iff (rst)
        (err_evt || irq_evt) |=> ((stat_q.err || !$past(err_evt)) && (stat_q.irq || !$past(irq_evt))));

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && !grp_ptr && size == SZ_BYTE && ofs == STAT_OFS && wdata[1] && !err_evt)
        |=> !stat_q.err);

    assert_nonbyte_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && !grp_ptr && size != SZ_BYTE)
        |=> ($stable(cmd_q) && $stable(stat_q.cap_hi) && $stable(stat_q.cap_lo)));

    assert_ptr_aligned_R12: assert property (@(posedge clk) disable iff (rst)
        ptr_q[1:0] == 2'b00);

endmodule

// File: rtl/bmide_rdmux.sv
module bmide_rdmux
    import bmide_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int IDX_W = $clog2(NCH)
) (
    input  logic                      rd,
    input  logic [IDX_W-1:0]          ch_idx,
    input  logic [NCH-1:0][IO_DW-1:0] chan_rdata,
    output logic [IO_DW-1:0]          rdata
);

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd && (ch_idx == c[IDX_W-1:0])) begin
                rdata = chan_rdata[c];
            end
        end
    end

endmodule

// File: rtl/bmide_regfile.sv
module bmide_regfile
    import bmide_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 3 + $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [1:0]        io_size,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    input  logic [NCH-1:0]    dma_active_i,
    input  logic [NCH-1:0]    err_evt_i,
    input  logic [NCH-1:0]    irq_evt_i,
    output logic [NCH-1:0]    start_o,
    output logic [NCH-1:0]    dir_o
);

    localparam int IDX_W = ADDR_W - 3;

    io_size_e                  sz;
    logic [NCH-1:0]            ch_sel;
    logic [IDX_W-1:0]          ch_idx;
    logic                      grp_ptr;
    logic [1:0]                ofs;
    logic [NCH-1:0][IO_DW-1:0] chan_rdata;

    assign sz = io_size_e'(io_size);

    bmide_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_decode (
        .clk     (clk),
        .rst     (rst),
        .addr    (io_addr),
        .rd      (io_rd),
        .wr      (io_wr),
        .ch_sel  (ch_sel),
        .ch_idx  (ch_idx),
        .grp_ptr (grp_ptr),
        .ofs     (ofs)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        bmide_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .sel        (ch_sel[c]),
            .wr         (io_wr),
            .grp_ptr    (grp_ptr),
            .ofs        (ofs),
            .size       (sz),
            .wdata      (io_wdata),
            .dma_active (dma_active_i[c]),
            .err_evt    (err_evt_i[c]),
            .irq_evt    (irq_evt_i[c]),
            .rdata      (chan_rdata[c]),
            .start      (start_o[c]),
            .dir        (dir_o[c])
        );
    end

    bmide_rdmux #(.NCH(NCH), .IDX_W(IDX_W)) u_rdmux (
        .rd         (io_rd),
        .ch_idx     (ch_idx),
        .chan_rdata (chan_rdata),
        .rdata      (io_rdata)
    );

    assert_rdata_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !io_rd |-> (io_rdata == 32'h0));

endmodule

// File: tb/bmide_regfile_tb_top.sv
module bmide_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [1:0]  dma_active_i = '0, err_evt_i = '0, irq_evt_i = '0;
    logic [1:0]  start_o, dir_o;

    always #2 clk = ~clk;

    bmide_regfile dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dma_active_i(dma_active_i), .err_evt_i(err_evt_i), .irq_evt_i(irq_evt_i),
        .start_o(start_o), .dir_o(dir_o)
    );

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t sb_q[$];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data at the falling edge of a read cycle
    always @(negedge clk) begin
        if (!rst && io_rd) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual unexpected read %h expected none", io_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(io_rdata, e.exp, e.tag);
            end
        end
    end

    task automatic slot();
        @(posedge clk); #1;
        io_rd = 1'b0; io_wr = 1'b0; err_evt_i = '0; irq_evt_i = '0;
    endtask

    task automatic wr_evt(logic [3:0] a, logic [1:0] s, logic [31:0] d,
                          logic [1:0] e, logic [1:0] i);
        slot();
        io_addr = a; io_size = s; io_wdata = d; io_wr = 1'b1;
        err_evt_i = e; irq_evt_i = i;
    endtask

    task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
        wr_evt(a, s, d, 2'b00, 2'b00);
    endtask

    task automatic rd(logic [3:0] a, logic [1:0] s, logic [31:0] exp, string tag);
        exp_t e;
        slot();
        e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        io_addr = a; io_size = s; io_rd = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        rd(4'h0, 2'd0, 32'h00, "R1 cmd ch0");
        rd(4'h2, 2'd0, 32'h00, "R1 status ch0");
        rd(4'hC, 2'd2, 32'h0, "R1 ptr ch1");
        chk({30'h0, start_o}, 32'h0, "R1 start_o");
        // R6 command storage
        wr(4'h0, 2'd0, 32'hFF);
        wr(4'h8, 2'd0, 32'h01);
        slot();
        chk({30'h0, start_o}, 32'h3, "R6 start_o");
        chk({30'h0, dir_o},   32'h1, "R6 dir_o");
        rd(4'h0, 2'd0, 32'h09, "R6 cmd ch0");
        rd(4'h8, 2'd0, 32'h01, "R6 R2 cmd ch1");
        // R3 filler offsets, R4 non-byte reads
        rd(4'h1, 2'd0, 32'hFF, "R3 ofs1");
        rd(4'hB, 2'd0, 32'hFF, "R3 ofs3 ch1");
        rd(4'h0, 2'd1, 32'h0000FFFF, "R4 half");
        rd(4'h8, 2'd2, 32'hFFFFFFFF, "R4 word");
        rd(4'h2, 2'd3, 32'hFFFFFFFF, "R4 rsvd");
        // R5 non-byte writes ignored
        wr(4'h0, 2'd1, 32'h0);
        wr(4'h2, 2'd2, 32'hFFFFFFFF);
        rd(4'h0, 2'd0, 32'h09, "R5 cmd kept");
        rd(4'h2, 2'd0, 32'h00, "R5 status kept");
        // R7 capability bits, R10 active mirror
        wr(4'h2, 2'd0, 32'h61);
        rd(4'h2, 2'd0, 32'h60, "R7 caps, bit0 ignores data");
        slot(); dma_active_i = 2'b01;
        rd(4'h2, 2'd0, 32'h61, "R10 active follows");
        wr(4'h2, 2'd0, 32'h00);
        rd(4'h2, 2'd0, 32'h01, "R7 caps cleared bit0 kept");
        // R11 events, R8 write-one-to-clear, R9 reserved
        wr_evt(4'h0, 2'd1, 32'h0, 2'b01, 2'b00);
        rd(4'h2, 2'd0, 32'h03, "R11 err set");
        wr_evt(4'h0, 2'd1, 32'h0, 2'b00, 2'b01);
        rd(4'h2, 2'd0, 32'h07, "R11 irq set");
        wr(4'h2, 2'd0, 32'h02);
        rd(4'h2, 2'd0, 32'h05, "R8 clear err only");
        wr(4'h2, 2'd0, 32'h9C);
        rd(4'h2, 2'd0, 32'h01, "R8 R9 clear irq, reserved zero");
        wr_evt(4'h2, 2'd0, 32'h06, 2'b01, 2'b00);
        rd(4'h2, 2'd0, 32'h03, "R11 set beats clear");
        slot(); dma_active_i = 2'b00;
        rd(4'h2, 2'd0, 32'h02, "R10 active drop");
        rd(4'hA, 2'd0, 32'h00, "R2 ch1 status untouched");
        // R12 pointer lanes
        wr(4'h4, 2'd2, 32'h12345677);
        rd(4'h4, 2'd2, 32'h12345674, "R12 word align");
        rd(4'h5, 2'd1, 32'h00003456, "R12 half read ofs1");
        wr(4'hE, 2'd0, 32'hFFFFFFAB);
        rd(4'hE, 2'd0, 32'hAB, "R12 byte lane");
        wr(4'hC, 2'd1, 32'h1234BEEF);
        rd(4'hC, 2'd2, 32'h00ABBEEC, "R12 half write");
        wr(4'hC, 2'd3, 32'hFFFFFFFF);
        rd(4'hC, 2'd2, 32'h00ABBEEC, "R12 rsvd write ignored");
        rd(4'h4, 2'd2, 32'h12345674, "R2 ch0 ptr separate");
        // R1 reset mid-run
        slot(); rst = 1'b1;
        slot(); slot(); rst = 1'b0;
        rd(4'h0, 2'd0, 32'h00, "R1 cmd after reset");
        rd(4'h2, 2'd0, 32'h00, "R1 status after reset");
        rd(4'h4, 2'd2, 32'h0, "R1 ptr after reset");
        slot();
        chk({30'h0, start_o}, 32'h0, "R1 start_o after reset");
        @(negedge clk);
        chk(sb_q.size(), 32'h0, "scoreboard drained");
        done = 1'b1;
        finish_run();
    end

endmodule